// File: doc/BRIEF.md
# Quadrature to Up/Down Clock Converter

This block turns the two phase signals of an incremental encoder, together with its once-per-turn reference track, into the pulse streams that a plain up/down counter can take directly. Separate active-low strobes count up or down, a level shows the direction of the latest count, and an active-low marker pulse comes out alongside a count when the reference track is active. Everything runs on one system clock.

Each of the three raw inputs is synchronised with two flops and then debounced. A new level is accepted only after it has been seen for a set number of consecutive clock cycles. Two static select pins choose one, two or four counts per encoder cycle. Each emitted pulse is stretched to a width that a 4-bit input gives. An encoder step that comes in while a pulse is still active is held back and handled as soon as that pulse ends.

Top module: `quad_clock_converter`

## Requirements
- R1: The resolution comes from `selDoubleN` and `selQuad`. `selDoubleN`=0 selects two counts per cycle whatever `selQuad` is. `selDoubleN`=1 with `selQuad`=0 selects one count per cycle. `selDoubleN`=1 with `selQuad`=1 selects four counts per cycle.
- R2: At four counts per cycle, every accepted change of phase A or of phase B gives exactly one pulse. A change of A counts up when A differs from B afterwards. A change of B counts up when A equals B afterwards. Every other change counts down, so A leading B counts up.
- R3: At two counts per cycle, only changes of phase A give pulses, with the same direction rule as R2. A change of B alone gives none.
- R4: At one count per cycle, a pulse comes only from a change of A while B is low. A rising gives an up pulse and A falling gives a down pulse.
- R5: `upClkN` and `dnClkN` idle high and are never low together. Each pulse is low for `pulseWidth` clock cycles, and a value of 0 gives 1 cycle.
- R6: `upDn` is 1 for up and 0 for down. It takes the new direction on the same clock edge as the start of a count pulse, and it changes at no other time.
- R7: `indexOutN` goes low with a count pulse, for the same cycles, when that count came from a change of A while B is low and the debounced reference input is high.
- R8: A raw input level must be seen in at least `VALID_CYCLES` consecutive synchronised samples before it is accepted. A shorter excursion gives no pulse.
- R9: For an accepted encoder step, the pulse goes low on the (`VALID_CYCLES`+3)-th rising clock edge after the input changes.
- R10: A step in which A and B both change in the same accepted sample gives no pulse and leaves `upDn` as it was.
- R11: During reset and after it, all pulse outputs are high and `upDn` is 1. Input levels that are already non-zero when reset is released give no pulse.
- R12: A step that is accepted while a pulse is active is held. Its pulse starts one clock edge after the active pulse has returned high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| phaseA | input | 1 | Encoder phase A, asynchronous |
| phaseB | input | 1 | Encoder phase B, asynchronous |
| indexIn | input | 1 | Encoder reference track, asynchronous |
| selDoubleN | input | 1 | Resolution select, low forces two counts per cycle |
| selQuad | input | 1 | Resolution select, four (1) or one (0) count per cycle |
| pulseWidth | input | WIDTH_BITS | Pulse width in clock cycles, 0 means 1 |
| upClkN | output | 1 | Active-low up-count strobe |
| dnClkN | output | 1 | Active-low down-count strobe |
| indexOutN | output | 1 | Active-low reference marker strobe |
| upDn | output | 1 | Direction of the latest count, 1 = up |

## Verification
Each count pulse is due on the (`VALID_CYCLES`+3)-th rising edge after the input change. That is two synchroniser flops, `VALID_CYCLES` debounce samples and one output register. A held step is due one edge after the previous pulse returns high. For every step the driver works out this due cycle and pushes it, with the direction, the marker flag and the width, into a queue. The monitor samples on the falling clock edge and compares each start of a pulse with the cycle stamp at the head of the queue. It counts how long the pulse stays low, and it reports a pulse that comes too early, too late or with no matching entry.

// File: rtl/qcc_pkg.sv
package qcc_pkg;

  typedef enum logic [1:0] {
    RES_X1 = 2'd0,
    RES_X2 = 2'd1,
    RES_X4 = 2'd2
  } resMode_t;

  // Strobes from the edge decoder (control) to the pulse shaper (datapath)
  typedef struct packed {
    logic fire;   // start a count pulse this cycle
    logic up;     // direction of that count
    logic mark;   // also emit the reference marker
  } countStrobe_t;

  function automatic resMode_t decodeMode(input logic doubleN, input logic quad);
    if (!doubleN)  return RES_X2;
    else if (quad) return RES_X4;
    else           return RES_X1;
  endfunction

endpackage

// File: rtl/qcc_input_filter.sv
module qcc_input_filter #(
  parameter int VALID_CYCLES = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic rawIn,
  output logic level,
  output logic settled
);

  localparam int RUN_W = (VALID_CYCLES < 2) ? 1 : $clog2(VALID_CYCLES + 1);
  localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(VALID_CYCLES - 1);
  localparam logic [1:0] WARM_DONE = 2'd3;

  logic [1:0]       syncQ;
  logic [RUN_W-1:0] runQ;
  logic             levelQ;
  logic [1:0]       warmQ;
  logic             sampled;

  assign sampled = syncQ[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ  <= '0;
      runQ   <= '0;
      levelQ <= 1'b0;
      warmQ  <= '0;
    end else begin
      syncQ <= {syncQ[0], rawIn};
      if (warmQ != WARM_DONE) begin
        // track the synchronised input until the synchroniser is filled
        warmQ  <= warmQ + 2'd1;
        levelQ <= sampled;
        runQ   <= '0;
      end else if (sampled == levelQ) begin
        runQ <= '0;
      end else if (runQ == RUN_LAST) begin
        levelQ <= sampled;
        runQ   <= '0;
      end else begin
        runQ <= runQ + 1'b1;
      end
    end
  end

  assign level   = levelQ;
  assign settled = (warmQ == WARM_DONE);

  // R8
  short_glitch_chk: assert property (@(posedge clk) disable iff (!rstN)
    (settled && (VALID_CYCLES > 1) && (sampled != levelQ) && (runQ == '0))
      |=> (levelQ == $past(levelQ)));

endmodule

// File: rtl/qcc_edge_decoder.sv
module qcc_edge_decoder
  import qcc_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         aLvl,
  input  logic         bLvl,
  input  logic         idxLvl,
  input  logic         settled,
  input  logic         busy,
  input  resMode_t     resMode,
  output countStrobe_t strobe
);

  logic prevA, prevB, armedQ;
  logic aMoved, bMoved, clash, take, dir, dirQuad;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevA  <= 1'b0;
      prevB  <= 1'b0;
      armedQ <= 1'b0;
    end else begin
      armedQ <= settled;
      // a step is only consumed while no pulse is running; otherwise it waits
      if (!busy) begin
        prevA <= aLvl;
        prevB <= bLvl;
      end
    end
  end

  assign aMoved  = aLvl ^ prevA;
  assign bMoved  = bLvl ^ prevB;
  assign clash   = aMoved & bMoved;
  assign dirQuad = aMoved ? (aLvl ^ bLvl) : ~(aLvl ^ bLvl);

  always_comb begin
    take = 1'b0;
    dir  = 1'b1;
    unique case (resMode)
      RES_X4: begin
        take = (aMoved | bMoved) & ~clash;
        dir  = dirQuad;
      end
      RES_X2: begin
        take = aMoved & ~clash;
        dir  = aLvl ^ bLvl;
      end
      RES_X1: begin
        take = aMoved & ~clash & ~bLvl;
        dir  = aLvl;
      end
      default: begin
        take = 1'b0;
        dir  = 1'b1;
      end
    endcase
  end

  assign strobe.fire = armedQ & ~busy & take;
  assign strobe.up   = dir;
  assign strobe.mark = aMoved & ~bLvl & idxLvl;

  // R4
  x1_phase_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.fire && resMode == RES_X1) |-> (!bLvl && (aLvl != prevA)));

  // R3
  x2_a_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.fire && resMode == RES_X2) |-> (aLvl != prevA));

  // R10
  clash_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((aLvl != prevA) && (bLvl != prevB)) |-> !strobe.fire);

endmodule

// File: rtl/qcc_pulse_shaper.sv
module qcc_pulse_shaper
  import qcc_pkg::*;
#(
  parameter int WIDTH_BITS = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  countStrobe_t          strobe,
  input  logic [WIDTH_BITS-1:0] pulseWidth,
  output logic                  upClkN,
  output logic                  dnClkN,
  output logic                  markN,
  output logic                  upDn,
  output logic                  busy
);

  localparam logic [WIDTH_BITS-1:0] ONE = WIDTH_BITS'(1);

  logic [WIDTH_BITS-1:0] holdQ, loadVal;
  logic upNQ, dnNQ, markNQ, upDnQ;

  assign loadVal = (pulseWidth == '0) ? ONE : pulseWidth;
  assign busy    = (holdQ != '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdQ  <= '0;
      upNQ   <= 1'b1;
      dnNQ   <= 1'b1;
      markNQ <= 1'b1;
      upDnQ  <= 1'b1;
    end else if (strobe.fire) begin
      holdQ  <= loadVal;
      upNQ   <= ~strobe.up;
      dnNQ   <= strobe.up;
      markNQ <= ~strobe.mark;
      upDnQ  <= strobe.up;
    end else if (busy) begin
      holdQ <= holdQ - ONE;
      if (holdQ == ONE) begin
        upNQ   <= 1'b1;
        dnNQ   <= 1'b1;
        markNQ <= 1'b1;
      end
    end
  end

  assign upClkN = upNQ;
  assign dnClkN = dnNQ;
  assign markN  = markNQ;
  assign upDn   = upDnQ;

  // R5
  exclusive_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(!upNQ && !dnNQ));

  // R6
  dir_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(upDnQ) |-> ($fell(upNQ) || $fell(dnNQ)));

  // R7
  mark_pair_chk: assert property (@(posedge clk) disable iff (!rstN)
    !markNQ |-> (!upNQ || !dnNQ));

  // R12
  no_retrigger_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && holdQ != ONE) |=> (upNQ == $past(upNQ) && dnNQ == $past(dnNQ)));

endmodule

// File: rtl/quad_clock_converter.sv
module quad_clock_converter
  import qcc_pkg::*;
#(
  parameter int VALID_CYCLES = 4,
  parameter int WIDTH_BITS   = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  phaseA,
  input  logic                  phaseB,
  input  logic                  indexIn,
  input  logic                  selDoubleN,
  input  logic                  selQuad,
  input  logic [WIDTH_BITS-1:0] pulseWidth,
  output logic                  upClkN,
  output logic                  dnClkN,
  output logic                  indexOutN,
  output logic                  upDn
);

  localparam int N_INPUTS = 3;

  logic [N_INPUTS-1:0] rawVec, lvlVec, settledVec;
  countStrobe_t        strobe;
  logic                busy;
  resMode_t            resMode;

  assign rawVec  = {indexIn, phaseB, phaseA};
  assign resMode = decodeMode(selDoubleN, selQuad);

  for (genvar gi = 0; gi < N_INPUTS; gi++) begin : g_filter
    qcc_input_filter #(.VALID_CYCLES(VALID_CYCLES)) u_filter (
      .clk     (clk),
      .rstN    (rstN),
      .rawIn   (rawVec[gi]),
      .level   (lvlVec[gi]),
      .settled (settledVec[gi])
    );
  end

  qcc_edge_decoder u_decoder (
    .clk     (clk),
    .rstN    (rstN),
    .aLvl    (lvlVec[0]),
    .bLvl    (lvlVec[1]),
    .idxLvl  (lvlVec[2]),
    .settled (&settledVec),
    .busy    (busy),
    .resMode (resMode),
    .strobe  (strobe)
  );

  qcc_pulse_shaper #(.WIDTH_BITS(WIDTH_BITS)) u_shaper (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .pulseWidth (pulseWidth),
    .upClkN     (upClkN),
    .dnClkN     (dnClkN),
    .markN      (indexOutN),
    .upDn       (upDn),
    .busy       (busy)
  );

  // R11
  reset_idle_chk: assert property (@(posedge clk)
    !rstN |=> (upClkN && dnClkN && indexOutN && upDn));

endmodule

// File: tb/tb_quad_clock_converter.sv
module tb_quad_clock_converter;

  localparam int CLK_PERIOD = 10;
  localparam int VALID      = 4;
  localparam int WB         = 4;
  localparam int LATENCY    = VALID + 3;
  localparam int WATCHDOG   = 20000;

  typedef struct {
    int    due;
    bit    up;
    bit    idx;
    int    width;
    string req;
  } expItem_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic phaseA = 1'b0, phaseB = 1'b0, indexIn = 1'b0;
  logic selDoubleN = 1'b1, selQuad = 1'b1;
  logic [WB-1:0] pulseWidth = 4'd2;
  logic upClkN, dnClkN, indexOutN, upDn;

  int cyc = 0;
  int total = 0;
  int bad = 0;
  bit finished = 0;
  bit monOn = 0;
  expItem_t expQ[$];

  int benchMode = 4;
  bit curA = 0, curB = 0, curIdx = 0;
  int curWidth = 1;
  int lowCnt = 0;
  bit lastUpN = 1, lastDnN = 1;

  quad_clock_converter #(.VALID_CYCLES(VALID), .WIDTH_BITS(WB)) dut (
    .clk(clk), .rstN(rstN), .phaseA(phaseA), .phaseB(phaseB), .indexIn(indexIn),
    .selDoubleN(selDoubleN), .selQuad(selQuad), .pulseWidth(pulseWidth),
    .upClkN(upClkN), .dnClkN(dnClkN), .indexOutN(indexOutN), .upDn(upDn)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // monitor: pops the scoreboard when a pulse starts, measures its width
  always @(negedge clk) begin
    if (rstN && monOn) begin
      if ((!upClkN && lastUpN) || (!dnClkN && lastDnN)) begin
        if (expQ.size() == 0) begin
          check(0, "R10", "pulse with no expectation at cycle", cyc, -1);
        end else begin
          expItem_t it;
          it = expQ.pop_front();
          check(cyc == it.due, "R9", {it.req, " start cycle"}, cyc, it.due);
          check((!upClkN) == it.up, it.req, "up strobe chosen", !upClkN, it.up);
          check(upDn == it.up, "R6", "direction level", upDn, it.up);
          check((!indexOutN) == it.idx, "R7", "marker with pulse", !indexOutN, it.idx);
          curWidth = it.width;
          lowCnt = 0;
        end
      end
      if (!upClkN || !dnClkN) lowCnt++;
      else if (lowCnt != 0) begin
        check(lowCnt == curWidth, "R5", "pulse width", lowCnt, curWidth);
        lowCnt = 0;
      end
      if (expQ.size() > 0 && cyc > expQ[0].due) begin
        check(0, expQ[0].req, "expected pulse missing, due", cyc, expQ[0].due);
        void'(expQ.pop_front());
      end
      lastUpN = upClkN;
      lastDnN = dnClkN;
    end
  end

  task automatic setMode(input int m);
    @(negedge clk);
    benchMode = m;
    // R1: selDoubleN=0 -> two counts, (1,0) -> one, (1,1) -> four
    if (m == 2) begin selDoubleN = 1'b0; selQuad = 1'b1; end
    else if (m == 1) begin selDoubleN = 1'b1; selQuad = 1'b0; end
    else begin selDoubleN = 1'b1; selQuad = 1'b1; end
    repeat (4) @(negedge clk);
  endtask

  task automatic setIndex(input bit v);
    @(negedge clk);
    indexIn = v;
    curIdx = v;
    repeat (LATENCY + 4) @(negedge clk);
  endtask

  // computes the expected pulse, if any, pushes it with its due cycle
  task automatic pushStep(input bit na, input bit nb, input int due);
    bit dA, dB, take, up;
    string req;
    dA = (na != curA);
    dB = (nb != curB);
    take = 0; up = 0; req = "R2";
    if (!(dA && dB)) begin
      if (benchMode == 4) begin
        take = dA || dB;
        up = dA ? (na != nb) : (na == nb);
        req = "R2";
      end else if (benchMode == 2) begin
        take = dA;
        up = (na != nb);
        req = "R3";
      end else begin
        take = dA && !nb;
        up = na;
        req = "R4";
      end
    end
    if (take)
      expQ.push_back('{due: due, up: up, idx: dA && !nb && curIdx,
                       width: (pulseWidth == 0) ? 1 : int'(pulseWidth), req: req});
    curA = na;
    curB = nb;
  endtask

  task automatic moveTo(input bit na, input bit nb, input int gap);
    @(negedge clk);
    pushStep(na, nb, cyc + LATENCY);
    phaseA = na;
    phaseB = nb;
    repeat (gap) @(negedge clk);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, WATCHDOG);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int t0;
    bit dirBefore;
    // R11: non-zero inputs across reset release must not count
    phaseA = 1'b1; phaseB = 1'b1; curA = 1; curB = 1;
    repeat (3) @(negedge clk);
    check(upClkN && dnClkN && indexOutN, "R11", "outputs idle in reset",
          {upClkN, dnClkN, indexOutN}, 3'b111);
    check(upDn == 1'b1, "R11", "direction in reset", upDn, 1);
    rstN = 1'b1;
    monOn = 1;
    repeat (15) @(negedge clk);
    check(upClkN && dnClkN && indexOutN, "R11", "outputs idle after release",
          {upClkN, dnClkN, indexOutN}, 3'b111);
    check(upDn == 1'b1, "R11", "direction after release", upDn, 1);

    // R2: four counts per cycle, up then down, marker on A edges with B low
    setMode(4);
    pulseWidth = 4'd2;
    moveTo(0, 1, 20); moveTo(0, 0, 20); moveTo(1, 0, 20); moveTo(1, 1, 20);
    setIndex(1);
    moveTo(1, 0, 20); moveTo(0, 0, 20); moveTo(0, 1, 20); moveTo(1, 1, 20);
    moveTo(0, 1, 20); moveTo(0, 0, 20); moveTo(1, 0, 20);

    // R3: two counts per cycle, B edges silent
    setMode(2);
    pulseWidth = 4'd4;
    moveTo(1, 1, 20); moveTo(0, 1, 20); moveTo(0, 0, 20); moveTo(1, 0, 20);
    moveTo(0, 0, 20); moveTo(0, 1, 20); moveTo(1, 1, 20);

    // R4: one count per cycle, width 0 acts as 1 (R5)
    setMode(1);
    pulseWidth = 4'd0;
    moveTo(0, 1, 20); moveTo(0, 0, 20); moveTo(1, 0, 20); moveTo(1, 1, 20);
    moveTo(1, 0, 20); moveTo(0, 0, 20); moveTo(0, 1, 20);
    setIndex(0);
    moveTo(0, 0, 20); moveTo(1, 0, 20); moveTo(0, 0, 20);

    // R10: both phases change together in four-count mode
    setMode(4);
    pulseWidth = 4'd2;
    moveTo(1, 0, 20);
    dirBefore = upDn;
    moveTo(0, 1, 25);
    check(upDn == dirBefore, "R10", "direction after clash", upDn, dirBefore);
    check(upClkN && dnClkN, "R10", "no strobe after clash", {upClkN, dnClkN}, 2'b11);

    // R8: excursion one sample shorter than the validation window
    moveTo(1, 1, 20);
    @(negedge clk);
    phaseA = 1'b0;
    repeat (VALID - 1) @(negedge clk);
    phaseA = 1'b1;
    repeat (25) @(negedge clk);
    check(upClkN && dnClkN, "R8", "short excursion ignored", {upClkN, dnClkN}, 2'b11);

    // R8: excursion exactly the window long gives both edges (two-count mode)
    setMode(2);
    pulseWidth = 4'd3;
    moveTo(1, 0, 20);
    @(negedge clk);
    t0 = cyc;
    pushStep(0, 0, t0 + LATENCY);
    phaseA = 1'b0;
    repeat (VALID) @(negedge clk);
    pushStep(1, 0, t0 + VALID + LATENCY);
    phaseA = 1'b1;
    repeat (30) @(negedge clk);

    // R12: step during a long pulse waits until the pulse ends
    setMode(4);
    pulseWidth = 4'd15;
    moveTo(0, 0, 30);
    @(negedge clk);
    t0 = cyc;
    pushStep(1, 0, t0 + LATENCY);
    phaseA = 1'b1;
    repeat (3) @(negedge clk);
    pushStep(1, 1, t0 + LATENCY + 15 + 1);
    phaseB = 1'b1;
    repeat (50) @(negedge clk);

    check(expQ.size() == 0, "R9", "expectations left over", expQ.size(), 0);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule